// File: doc/BRIEF.md
# Lane-Partitioned 128-bit Vector Add/Subtract Unit

This unit adds or subtracts two 128-bit operands treated as packed integer lanes. One instruction-style request selects the lane width (8, 16, 32 or 64 bits) and the operator. The same operator is applied to every lane in the same cycle. Sums wrap around inside each lane, and no carry or borrow ever passes from one lane into the next. The result is registered, so it appears one clock after the request.

Scalar values use a fixed slot: the leftmost 32-bit word of the vector. Byte 0 is the most significant byte, so that slot is bits [127:96]. A separate 32-bit output always presents this slot of the registered result. A scalar mode replaces the slot of operand B with a 32-bit scalar input. It then forces the three lower words of the result to zero.

A two-state controller tracks the output register. **S_IDLE** means no fresh result is present. **S_VALID** means the result register was loaded on the last edge. The transition *accept* (S_IDLE→S_VALID) or *refill* (S_VALID→S_VALID) is taken when `in_valid` is high. The transition *drain* (S_VALID→S_IDLE) or *wait* (S_IDLE→S_IDLE) is taken when it is low. A synchronous reset forces S_IDLE.

Top module: `simd_addsub_unit`

## Requirements
- R1: With `lane_mode`=0 (sixteen 8-bit lanes), each byte of the result is the wrapped sum of the matching operand bytes, and no carry enters the neighbouring byte.
- R2: With `lane_mode`=1 (eight 16-bit lanes), each 16-bit lane wraps independently.
- R3: With `lane_mode`=2 (four 32-bit lanes), each 32-bit lane wraps independently.
- R4: With `lane_mode`=3 (two 64-bit lanes), each 64-bit lane wraps independently.
- R5: With `op_sub`=1, each lane produces A minus B modulo 2^lane-width. This is formed as A + ~B + 1, with the +1 injected at the least significant bit of every lane.
- R6: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise. `result` carries that request's outcome in that cycle.
- R7: While `in_valid` is low, `result` and `scalar_out` keep their last value whatever the other inputs do.
- R8: `scalar_out` always equals bits [127:96] of `result`.
- R9: With `bcast_en`=1, bits [127:96] of operand B are replaced by `scalar_in`. Bits [95:0] of the result are zero, and the top word is computed per the selected lane width.
- R10: `rst` high at a clock edge clears `result` to zero and `out_valid` to 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| lane_mode | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit, 3: 64-bit lanes |
| op_sub | input | 1 | 0 add, 1 subtract (A − B) |
| bcast_en | input | 1 | Scalar mode: use `scalar_in` as B's top word, zero the rest |
| scalar_in | input | 32 | Scalar operand for scalar mode |
| opnd_a | input | 128 | Operand A |
| opnd_b | input | 128 | Operand B |
| out_valid | output | 1 | Result is fresh this cycle |
| result | output | 128 | Registered lane-wise result |
| scalar_out | output | 32 | Preferred-slot word of `result` |

## Verification
The embedded properties check several things on every cycle: the one-cycle valid timing, that the result holds while idle, that the lower words are zero after a scalar-mode request, the coupling of `scalar_out` to the top word, and the reset clearing. The arithmetic itself can only be shown by the bench's scenarios, which compare against an independent bit-serial model. These cover lane isolation under all-ones carry patterns in every width, borrow handling in subtraction, and scalar-slot placement.

// File: rtl/simd_pkg.sv
package simd_pkg;
    localparam int VEC_W  = 128;
    localparam int SLOT_W = 32;

    typedef enum logic [1:0] {
        LM_B8  = 2'd0,
        LM_H16 = 2'd1,
        LM_W32 = 2'd2,
        LM_D64 = 2'd3
    } lane_mode_e;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_VALID = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/simd_operand_prep.sv
module simd_operand_prep #(
    parameter int W  = 128,
    parameter int SW = 32
) (
    input  logic [W-1:0]  b_in,
    input  logic [SW-1:0] scalar_in,
    input  logic          bcast_en,
    input  logic          op_sub,
    output logic [W-1:0]  b_eff
);
    logic [W-1:0] b_sel;

    always_comb begin
        b_sel = b_in;
        if (bcast_en)
            b_sel[W-1 -: SW] = scalar_in;
        b_eff = op_sub ? ~b_sel : b_sel;
    end
endmodule

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
    parameter int W    = 128,
    parameter int SEGW = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   lane_mode,
    input  logic         cin_lane,
    output logic [W-1:0] sum
);
    localparam int NSEG = W / SEGW;

    logic [NSEG-1:0] seg_cout;
    logic [NSEG-1:0] seg_cin;
    logic [7:0]      lane_segs;
    logic [7:0]      lane_mask;

    assign lane_segs = 8'd1 << lane_mode;
    assign lane_mask = lane_segs - 8'd1;

    genvar j;
    generate
        for (j = 0; j < NSEG; j++) begin : g_seg
            logic lane_start;
            assign lane_start = ((8'(j) & lane_mask) == 8'd0);
            if (j == 0) begin : g_first
                assign seg_cin[j] = cin_lane;
            end else begin : g_rest
                // carry is broken at every lane boundary
                assign seg_cin[j] = lane_start ? cin_lane : seg_cout[j-1];
            end
            assign {seg_cout[j], sum[j*SEGW +: SEGW]} =
                {1'b0, a[j*SEGW +: SEGW]} + {1'b0, b[j*SEGW +: SEGW]}
                + {{SEGW{1'b0}}, seg_cin[j]};
        end
    endgenerate
endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit
    import simd_pkg::*;
#(
    parameter int W  = VEC_W,
    parameter int SW = SLOT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    lane_mode,
    input  logic          op_sub,
    input  logic          bcast_en,
    input  logic [SW-1:0] scalar_in,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    output logic          out_valid,
    output logic [W-1:0]  result,
    output logic [SW-1:0] scalar_out
);
    localparam int LOW_W = W - SW;

    ctl_state_e   state_q, state_d;
    logic [W-1:0] b_eff;
    logic [W-1:0] sum;
    logic [W-1:0] res_d;
    logic [W-1:0] res_q;

    simd_operand_prep #(.W(W), .SW(SW)) u_prep (
        .b_in      (opnd_b),
        .scalar_in (scalar_in),
        .bcast_en  (bcast_en),
        .op_sub    (op_sub),
        .b_eff     (b_eff)
    );

    simd_seg_adder #(.W(W), .SEGW(8)) u_add (
        .a         (opnd_a),
        .b         (b_eff),
        .lane_mode (lane_mode),
        .cin_lane  (op_sub),
        .sum       (sum)
    );

    always_comb begin
        res_d = sum;
        if (bcast_en)
            res_d[LOW_W-1:0] = '0;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = in_valid ? S_VALID : S_IDLE;   // accept / wait
            S_VALID: state_d = in_valid ? S_VALID : S_IDLE;   // refill / drain
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst)           res_q <= '0;
        else if (in_valid) res_q <= res_d;
    end

    assign out_valid  = (state_q == S_VALID);
    assign result     = res_q;
    assign scalar_out = res_q[W-1 -: SW];

    p_valid_rise_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_fall_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
    p_slot_r8: assert property (@(posedge clk) disable iff (rst)
        scalar_out == result[W-1 -: SW]);
    p_bcast_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bcast_en) |=> (result[LOW_W-1:0] == '0));
    p_reset_r10: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));
endmodule

// File: tb/sim_simd_addsub_unit.sv
module sim_simd_addsub_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   lane_mode = 2'd0;
    logic         op_sub = 1'b0;
    logic         bcast_en = 1'b0;
    logic [31:0]  scalar_in = '0;
    logic [127:0] opnd_a = '0;
    logic [127:0] opnd_b = '0;
    logic         out_valid;
    logic [127:0] result;
    logic [31:0]  scalar_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    simd_addsub_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .lane_mode(lane_mode),
        .op_sub(op_sub), .bcast_en(bcast_en), .scalar_in(scalar_in),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
        .result(result), .scalar_out(scalar_out)
    );

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input logic [1:0] m, input logic s,
                                           input logic bc, input logic [31:0] sc);
        logic [127:0] bb, r;
        logic c;
        int lw;
        bb = b;
        if (bc) bb[127:96] = sc;
        if (s) bb = ~bb;
        lw = 8 << m;
        c = 1'b0;
        for (int k = 0; k < 128; k++) begin
            if (k % lw == 0) c = s;
            r[k] = a[k] ^ bb[k] ^ c;
            c = (a[k] & bb[k]) | (a[k] & c) | (bb[k] & c);
        end
        if (bc) r[95:0] = '0;
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [127:0] a, input logic [127:0] b,
                          input logic [1:0] m, input logic s, input logic bc,
                          input logic [31:0] sc);
        logic [127:0] exp;
        exp = model(a, b, m, s, bc, sc);
        @(negedge clk);
        in_valid = 1'b1; opnd_a = a; opnd_b = b; lane_mode = m;
        op_sub = s; bcast_en = bc; scalar_in = sc;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, result, exp);
        check({req, "/R8 scalar"}, {96'd0, scalar_out}, {96'd0, exp[127:96]});
    endtask

    task automatic t_reset();
        check("R10 reset result", result, '0);
        check("R10 reset valid", {127'd0, out_valid}, 128'd0);
    endtask

    task automatic t_lanes();
        // all-ones plus one per byte: only true lane isolation gives these values
        run_op("R1", {16{8'hFF}}, {16{8'h01}}, 2'd0, 1'b0, 1'b0, '0);
        check("R1 isolation", result, '0);
        run_op("R2", {16{8'hFF}}, {16{8'h01}}, 2'd1, 1'b0, 1'b0, '0);
        check("R2 isolation", result, {8{16'h0100}});
        run_op("R3", {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, 2'd2, 1'b0, 1'b0, '0);
        run_op("R4", {2{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'd1}}, 2'd3, 1'b0, 1'b0, '0);
        check("R4 isolation", result, '0);
        run_op("R1 mixed", 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
               128'h8877_6655_4433_2211_F0E1_D2C3_B4A5_9687, 2'd0, 1'b0, 1'b0, '0);
        run_op("R3 mixed", 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
               128'h8877_6655_4433_2211_F0E1_D2C3_B4A5_9687, 2'd2, 1'b0, 1'b0, '0);
    endtask

    task automatic t_sub();
        // 0 - 1 must borrow-wrap within each lane only
        run_op("R5 b8", '0, {16{8'h01}}, 2'd0, 1'b1, 1'b0, '0);
        check("R5 b8 wrap", result, {16{8'hFF}});
        run_op("R5 h16", {8{16'h0100}}, {8{16'h0001}}, 2'd1, 1'b1, 1'b0, '0);
        check("R5 h16 borrow", result, {8{16'h00FF}});
        run_op("R5 d64", 128'h5, 128'h7, 2'd3, 1'b1, 1'b0, '0);
        run_op("R5 w32", 128'hDEAD_BEEF_0000_0000_1234_5678_FFFF_FFFF,
               128'h0000_0001_0000_0001_8765_4321_FFFF_FFFF, 2'd2, 1'b1, 1'b0, '0);
    endtask

    task automatic t_timing_hold();
        logic [127:0] held;
        @(negedge clk);
        in_valid = 1'b1; opnd_a = 128'h11; opnd_b = 128'h22;
        lane_mode = 2'd0; op_sub = 1'b0; bcast_en = 1'b0;
        check("R6 no early valid", {127'd0, out_valid}, 128'd0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 valid after one", {127'd0, out_valid}, 128'd1);
        check("R6 result", result, 128'h33);
        held = result;
        opnd_a = '1; opnd_b = '1; op_sub = 1'b1; bcast_en = 1'b1; scalar_in = 32'hABCD_0123;
        @(negedge clk);
        check("R6 valid drops", {127'd0, out_valid}, 128'd0);
        @(negedge clk);
        check("R7 hold", result, held);
        check("R7 hold scalar", {96'd0, scalar_out}, {96'd0, held[127:96]});
    endtask

    task automatic t_bcast();
        run_op("R9 add", {32'h1000_0001, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF},
               {32'h0, {3{32'h1234_5678}}}, 2'd2, 1'b0, 1'b1, 32'h0FFF_FFFF);
        check("R9 add value", result, {32'h2000_0000, 96'd0});
        run_op("R9 sub b8", {32'h0102_0304, 96'h1}, '1, 2'd0, 1'b1, 1'b1, 32'h0203_0401);
        check("R9 sub value", result, {32'hFFFF_FF03, 96'd0});
    endtask

    task automatic t_mid_reset();
        run_op("R10 pre", {16{8'h5A}}, {16{8'h11}}, 2'd1, 1'b0, 1'b0, '0);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        check("R10 mid result", result, '0);
        check("R10 mid valid", {127'd0, out_valid}, 128'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_lanes();
        t_sub();
        t_timing_hold();
        t_bcast();
        t_mid_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule